// File: doc/BRIEF.md
# SVGA 800x600 Raster Timing Generator

This block produces the scan timing for an 800 by 600 display refreshed about sixty times a second, driven by a 40 MHz pixel clock. Each clock period is one pixel slot of 25 ns. A column counter walks through every line. A row counter moves forward one step each time a line completes, so all vertical timing is counted in whole lines.

Lines and frames both begin with their sync pulse. The back porch follows, then the visible area, then the front porch. With the default settings a line takes 1056 clocks (128 sync, 88 back porch, 800 visible, 40 front porch). A frame takes 628 lines (4 sync, 23 back porch, 600 visible, 1 front porch).

The pixel source supplies one on/off bit for each of red, green and blue, which gives eight colours. The block passes that colour through only inside the visible area and reports which pixel it belongs to. Both sync outputs, the colour, the visible flag and the position are registered in one output stage, so they all change on the same clock edge.

Top module: `svga_raster_gen`

## Requirements
- R1: A line lasts H_SYNC+H_BACK+H_FRONT+H_ACT clocks (1056 by default). `hsync_n` falls once per line and stays low for exactly H_SYNC clocks (128 by default) at the start of each line.
- R2: A frame lasts V_SYNC+V_BACK+V_ACT+V_FRONT lines (628 by default). `vsync_n` falls on the same edge as `hsync_n` at a line start and stays low for exactly V_SYNC whole lines (4 by default).
- R3: Both syncs are active low. Each is 0 only inside its own sync region and 1 everywhere else on its axis.
- R4: The row position changes only at the end of a complete line. Within one line, every output that depends on the row keeps the same value.
- R5: `de` is 1 only when the column lies in the horizontal visible region and the row lies in the vertical visible region.
- R6: `rgb_out` bit 2 is red, bit 1 is green and bit 0 is blue. When `de` is 1, `rgb_out` equals the `rgb_in` value sampled on the same edge. When `de` is 0, `rgb_out` is 3'b000.
- R7: While `de` is 1, `col` runs 0..H_ACT-1 from left to right along a line, and `row` runs 0..V_ACT-1 from top to bottom, then wraps to the top-left. While `de` is 0, both read 0.
- R8: While `rst` is high, the outputs read `hsync_n`=0, `vsync_n`=0, `de`=0, `rgb_out`=0, `col`=0 and `row`=0. The first edge after reset outputs column 0 of line 0, which is the start of both sync regions.
- R9: The sync outputs, `de`, `rgb_out`, `col` and `row` all come from one register stage. For pixel slot p counted from reset release, all of them show slot p on edge p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| rgb_in | input | 3 | Pixel colour: bit 2 red, bit 1 green, bit 0 blue |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb_out | output | 3 | Gated colour, zero outside the visible area |
| de | output | 1 | High for visible pixels |
| col | output | $clog2(H_ACT) | Visible column, 0 outside the visible area |
| row | output | $clog2(V_ACT) | Visible row, 0 outside the visible area |

## Verification
A reduced configuration (19-clock lines, 11-line frames) is compared with an arithmetic model on every cycle across more than a hundred frames. This exposes any off-by-one at each region boundary on either axis, and any slip in row stepping. The default configuration runs alongside it for about 33 lines. That run confirms the 1056-clock line, the 128-clock horizontal pulse and the 4-line vertical pulse, and checks that the first visible row starts on line 27. The colour input cycles through all eight codes with a stride that does not divide the line length, so blanking that leaks colour shows up. So does colour taken from the wrong edge.

// File: rtl/svga_tim_pkg.sv
package svga_tim_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    typedef struct packed {
        logic       hs_n;
        logic       vs_n;
        logic       de;
        logic [2:0] rgb;
    } pix_ctl_t;

    localparam pix_ctl_t PIX_RESET = '{hs_n: 1'b0, vs_n: 1'b0, de: 1'b0, rgb: 3'b000};

    function automatic seg_e seg_of(input int unsigned c,
                                    input int unsigned sync_end,
                                    input int unsigned back_end,
                                    input int unsigned act_end);
        if (c < sync_end)      return SEG_SYNC;
        else if (c < back_end) return SEG_BACK;
        else if (c < act_end)  return SEG_ACT;
        else                   return SEG_FRONT;
    endfunction

endpackage

// File: rtl/svga_axis.sv
module svga_axis
    import svga_tim_pkg::*;
#(
    parameter int SYNC  = 128,
    parameter int BACK  = 88,
    parameter int ACT   = 800,
    parameter int FRONT = 40,
    parameter int PW    = $clog2(ACT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output seg_e          seg,
    output logic [PW-1:0] pos,
    output logic          wrap
);
    localparam int TOTAL    = SYNC + BACK + ACT + FRONT;
    localparam int CW       = $clog2(TOTAL);
    localparam int BACK_END = SYNC + BACK;
    localparam int ACT_END  = BACK_END + ACT;

    logic [CW-1:0] cnt;
    logic [CW-1:0] off;
    logic          at_max;

    assign at_max = (cnt == CW'(TOTAL - 1));
    assign wrap   = step && at_max;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (wrap)  cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
    end

    always_comb begin
        seg = seg_of(32'(cnt), SYNC, BACK_END, ACT_END);
        off = cnt - CW'(BACK_END);
        pos = (seg == SEG_ACT) ? PW'(off) : '0;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TOTAL - 1));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_max) |=> (cnt == '0));

    // R1
    cnt_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !at_max) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/svga_out_stage.sv
module svga_out_stage
    import svga_tim_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int ROW_W = 10,
    parameter int H_ACT = 800
) (
    input  logic             clk,
    input  logic             rst,
    input  seg_e             h_seg,
    input  seg_e             v_seg,
    input  logic [COL_W-1:0] h_pos,
    input  logic [ROW_W-1:0] v_pos,
    input  logic [2:0]       rgb_in,
    output logic             hsync_n,
    output logic             vsync_n,
    output logic             de,
    output logic [2:0]       rgb_out,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    pix_ctl_t         ctl_d, ctl_q;
    logic [COL_W-1:0] col_d;
    logic [ROW_W-1:0] row_d;

    always_comb begin
        ctl_d.hs_n = (h_seg != SEG_SYNC);
        ctl_d.vs_n = (v_seg != SEG_SYNC);
        ctl_d.de   = (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
        ctl_d.rgb  = ctl_d.de ? rgb_in : 3'b000;
        col_d      = ctl_d.de ? h_pos : '0;
        row_d      = ctl_d.de ? v_pos : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= PIX_RESET;
            col   <= '0;
            row   <= '0;
        end else begin
            ctl_q <= ctl_d;
            col   <= col_d;
            row   <= row_d;
        end
    end

    assign hsync_n = ctl_q.hs_n;
    assign vsync_n = ctl_q.vs_n;
    assign de      = ctl_q.de;
    assign rgb_out = ctl_q.rgb;

    // R5
    de_sync_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync_n && vsync_n));

    // R6
    rgb_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (rgb_out == 3'b000));

    // R6
    rgb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> (rgb_out == $past(rgb_in)));

    // R7
    pos_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !de |-> (col == '0 && row == '0));

    // R7
    col_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(col) < H_ACT);

endmodule

// File: rtl/svga_raster_gen.sv
module svga_raster_gen
    import svga_tim_pkg::*;
#(
    parameter int H_SYNC  = 128,
    parameter int H_BACK  = 88,
    parameter int H_ACT   = 800,
    parameter int H_FRONT = 40,
    parameter int V_SYNC  = 4,
    parameter int V_BACK  = 23,
    parameter int V_ACT   = 600,
    parameter int V_FRONT = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 rgb_in,
    output logic                       hsync_n,
    output logic                       vsync_n,
    output logic [2:0]                 rgb_out,
    output logic                       de,
    output logic [$clog2(H_ACT)-1:0]   col,
    output logic [$clog2(V_ACT)-1:0]   row
);
    localparam int COL_W = $clog2(H_ACT);
    localparam int ROW_W = $clog2(V_ACT);

    seg_e             h_seg, v_seg;
    logic [COL_W-1:0] h_pos;
    logic [ROW_W-1:0] v_pos;
    logic             h_wrap, v_wrap;

    svga_axis #(
        .SYNC(H_SYNC), .BACK(H_BACK), .ACT(H_ACT), .FRONT(H_FRONT), .PW(COL_W)
    ) h_axis_i (
        .clk(clk), .rst(rst), .step(1'b1),
        .seg(h_seg), .pos(h_pos), .wrap(h_wrap)
    );

    svga_axis #(
        .SYNC(V_SYNC), .BACK(V_BACK), .ACT(V_ACT), .FRONT(V_FRONT), .PW(ROW_W)
    ) v_axis_i (
        .clk(clk), .rst(rst), .step(h_wrap),
        .seg(v_seg), .pos(v_pos), .wrap(v_wrap)
    );

    svga_out_stage #(
        .COL_W(COL_W), .ROW_W(ROW_W), .H_ACT(H_ACT)
    ) out_i (
        .clk(clk), .rst(rst),
        .h_seg(h_seg), .v_seg(v_seg), .h_pos(h_pos), .v_pos(v_pos),
        .rgb_in(rgb_in),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .rgb_out(rgb_out), .col(col), .row(row)
    );

    // R2
    frame_on_line_chk: assert property (@(posedge clk) disable iff (rst)
        v_wrap |-> h_wrap);

    // R2
    vfall_at_hfall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> $fell(hsync_n));

    // R4
    row_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(de) && de) |-> (row == $past(row)));

endmodule

// File: tb/svga_raster_gen_tb_top.sv
module svga_raster_gen_tb_top;

    localparam int SHS = 4, SHB = 3, SHA = 10, SHF = 2;
    localparam int SVS = 2, SVB = 3, SVA = 5,  SVF = 1;
    localparam int SHT = SHS + SHB + SHA + SHF;
    localparam int SVT = SVS + SVB + SVA + SVF;
    localparam int BHS = 128, BHB = 88, BHA = 800, BHF = 40;
    localparam int BVS = 4, BVB = 23, BVA = 600, BVF = 1;
    localparam int BHT = BHS + BHB + BHA + BHF;
    localparam int RUN = 33 * BHT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] rgb_in = 3'b000;

    logic s_hs, s_vs, s_de; logic [2:0] s_rgb;
    logic [$clog2(SHA)-1:0] s_col; logic [$clog2(SVA)-1:0] s_row;
    logic b_hs, b_vs, b_de; logic [2:0] b_rgb;
    logic [$clog2(BHA)-1:0] b_col; logic [$clog2(BVA)-1:0] b_row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    svga_raster_gen #(.H_SYNC(SHS), .H_BACK(SHB), .H_ACT(SHA), .H_FRONT(SHF),
                      .V_SYNC(SVS), .V_BACK(SVB), .V_ACT(SVA), .V_FRONT(SVF)) dut_i (
        .clk(clk), .rst(rst), .rgb_in(rgb_in),
        .hsync_n(s_hs), .vsync_n(s_vs), .rgb_out(s_rgb), .de(s_de),
        .col(s_col), .row(s_row));

    svga_raster_gen dut_big_i (
        .clk(clk), .rst(rst), .rgb_in(rgb_in),
        .hsync_n(b_hs), .vsync_n(b_vs), .rgb_out(b_rgb), .de(b_de),
        .col(b_col), .row(b_row));

    function automatic logic [2:0] pat(input int k);
        return 3'((k * 5 + 3) % 8);
    endfunction

    function automatic void model(input int p, input int hs, input int hb, input int ha,
                                  input int hf, input int vs, input int vb, input int va,
                                  input int vf, output bit hsn, output bit vsn,
                                  output bit de, output int c, output int r);
        int ht, vt, h, v;
        bit hv, vv;
        ht  = hs + hb + ha + hf;
        vt  = vs + vb + va + vf;
        h   = p % ht;
        v   = (p / ht) % vt;
        hsn = (h >= hs);
        vsn = (v >= vs);
        hv  = (h >= hs + hb) && (h < hs + hb + ha);
        vv  = (v >= vs + vb) && (v < vs + vb + va);
        de  = hv && vv;
        c   = de ? h - hs - hb : 0;
        r   = de ? v - vs - vb : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_pix(input string tag, input int p, input logic [2:0] drv,
                           input bit big);
        bit ehs, evs, ede; int ec, er;
        int hs, vs, de, rgb, c, r;
        if (big) begin
            model(p, BHS, BHB, BHA, BHF, BVS, BVB, BVA, BVF, ehs, evs, ede, ec, er);
            hs = int'(b_hs); vs = int'(b_vs); de = int'(b_de); rgb = int'(b_rgb);
            c = int'(b_col); r = int'(b_row);
        end else begin
            model(p, SHS, SHB, SHA, SHF, SVS, SVB, SVA, SVF, ehs, evs, ede, ec, er);
            hs = int'(s_hs); vs = int'(s_vs); de = int'(s_de); rgb = int'(s_rgb);
            c = int'(s_col); r = int'(s_row);
        end
        // R1 R3 hsync, R2 vsync, R5 de, R6 rgb, R7 position, R9 alignment
        check(hs == int'(ehs), {tag, " R1/R3 hsync_n"}, hs, int'(ehs));
        check(vs == int'(evs), {tag, " R2/R3 vsync_n"}, vs, int'(evs));
        check(de == int'(ede), {tag, " R5 de"}, de, int'(ede));
        check(rgb == (ede ? int'(drv) : 0), {tag, " R6 rgb_out"}, rgb, ede ? int'(drv) : 0);
        check(c == ec, {tag, " R7 col"}, c, ec);
        check(r == er, {tag, " R7 R4 row"}, r, er);
    endtask

    initial begin
        #(4 * (RUN + 200));
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit   s_hp, s_vp, b_hp;
        int   s_hlow, s_vlow, b_hlow, b_vlow;
        int   s_vfall, b_hfall;
        s_hp = 1'b0; s_vp = 1'b0; b_hp = 1'b0;
        s_hlow = 0; s_vlow = 0; b_hlow = 0; b_vlow = 0;
        s_vfall = -1; b_hfall = -1;

        rgb_in = 3'b111;
        repeat (3) @(negedge clk);
        // R8 reset state on both instances
        check(s_hs == 1'b0 && s_vs == 1'b0, "R8 reset syncs", int'({s_hs, s_vs}), 0);
        check(s_de == 1'b0 && s_rgb == 3'b000, "R8 reset de/rgb", int'({s_de, s_rgb}), 0);
        check(s_col == '0 && s_row == '0, "R8 reset position", int'(s_col) + int'(s_row), 0);
        check(b_hs == 1'b0 && b_vs == 1'b0 && b_de == 1'b0 && b_rgb == 3'b000,
              "R8 reset default instance", int'({b_hs, b_vs, b_de, b_rgb}), 0);

        rst = 1'b0;
        rgb_in = pat(1);
        for (int k = 1; k <= RUN; k++) begin
            logic [2:0] drv;
            drv = rgb_in;
            @(negedge clk);
            // R9: edge k shows slot k-1 on every output
            cmp_pix("small", k - 1, drv, 1'b0);
            cmp_pix("default", k - 1, drv, 1'b1);

            // R1 hsync low run (small)
            if (!s_hs) s_hlow++;
            if (s_hs && !s_hp) begin
                check(s_hlow == SHS, "R1 small hsync width", s_hlow, SHS);
                s_hlow = 0;
            end
            s_hp = s_hs;
            // R2 vsync low run and frame period (small)
            if (!s_vs) s_vlow++;
            if (s_vs && !s_vp) begin
                check(s_vlow == SVS * SHT, "R2 small vsync width", s_vlow, SVS * SHT);
                s_vlow = 0;
            end
            if (!s_vs && s_vp) begin
                if (s_vfall >= 0)
                    check(k - s_vfall == SVT * SHT, "R2 small frame period",
                          k - s_vfall, SVT * SHT);
                s_vfall = k;
            end
            s_vp = s_vs;
            // R1 default line period and hsync width
            if (!b_hs) b_hlow++;
            if (b_hs && !b_hp) begin
                check(b_hlow == BHS, "R1 default hsync width", b_hlow, BHS);
                b_hlow = 0;
            end
            if (!b_hs && b_hp) begin
                if (b_hfall >= 0)
                    check(k - b_hfall == BHT, "R1 default line period", k - b_hfall, BHT);
                b_hfall = k;
            end
            b_hp = b_hs;
            // R2 default vsync width: 4 whole lines
            if (!b_vs) b_vlow++;
            if (k == BVS * BHT + 1)
                check(b_vlow == BVS * BHT, "R2 default vsync width", b_vlow, BVS * BHT);

            rgb_in = pat(k + 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule